// File: doc/BRIEF.md
# Serial Flash Page Load and Read Data Register

This block sits behind a boundary-scan TAP controller and gives a serial programming path into a word-organised flash. The TAP controller supplies the current instruction code and single-cycle strobes for the capture, shift, update and run-idle states. All logic runs on the test clock. Three instruction codes select this block. Any other code leaves it idle with its serial output low.

The command instruction selects a 15-bit shift register. A capture loads the result word of the previous command, so that result shifts out while the next command shifts in. An update presents the command to the flash and marks it armed. The next run-idle strobe then produces one execute pulse. Two command opcodes set the word address counter one byte at a time.

The page-load and page-read instructions select only the low 8 bits of the same shift register. Bytes are paired into 16-bit words with the low byte first. In page load, each update takes one byte. Every second byte produces a single-cycle write pulse into the page buffer. The counter advances before each low byte except the first one after the instruction is selected. In page read, each capture takes one byte of the word at the counter. The counter advances after each high byte, including the first.

Top module: `jtag_page_dr`

## Requirements
- R1: After reset, `tdo`, `pb_we`, `cmd_load` and `cmd_exec` are 0 and `rd_addr` is 0.
- R2: With instruction 4'h5, a capture loads all 15 bits of `cmd_result`. Each shift moves the register one place toward bit 0, with `tdi` entering bit 14. `tdo` always shows bit 0.
- R3: With instruction 4'h5, an update copies the register to `cmd_out` and pulses `cmd_load` for one cycle, in the cycle after the update strobe. The first run-idle strobe after that update pulses `cmd_exec` in the following cycle. Further run-idle strobes give no pulse until another update occurs.
- R4: A command update whose bits 14:8 equal 7'h03 loads bits 7:0 into the low byte of the word address. Bits 14:8 equal to 7'h07 load bits 7:0 into the high byte. The address is visible on `rd_addr`.
- R5: With instruction 4'h6 or 4'h7, shifting uses only bits 7:0: `tdi` enters bit 7 and `tdo` shows bit 0. Bits 14:8 keep their value.
- R6: With instruction 4'h6, updates alternate low byte, then high byte, starting with low. A high-byte update pulses `pb_we` for exactly one cycle, in the cycle after the strobe. `pb_wdata` is {high byte, low byte} and `pb_addr` is the word address.
- R7: With instruction 4'h6, the address increments at each low-byte update except the first one since the instruction was selected. After a full page is loaded, the address still points at the last word.
- R8: With instruction 4'h7, captures alternate low byte, then high byte, starting with low. Each capture loads bits 7:0 with that byte of `rd_data`, read at `rd_addr`.
- R9: With instruction 4'h7, the address increments after every high-byte capture. After a full page is read, it points at the first word of the next page.
- R10: Any change of instruction code restarts the low/high alternation and the first-byte rule. The word address is kept.
- R11: With any other instruction code, all strobes are ignored, `tdo` is 0, and the register, address and outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| ir_code | input | 4 | Current instruction code |
| cap_dr | input | 1 | Capture-state strobe |
| shift_dr | input | 1 | Shift-state strobe |
| upd_dr | input | 1 | Update-state strobe |
| rti | input | 1 | Run-idle strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| cmd_out | output | 15 | Command applied to the flash |
| cmd_load | output | 1 | One-cycle pulse when `cmd_out` is updated |
| cmd_exec | output | 1 | One-cycle command execute pulse |
| cmd_result | input | 15 | Result of the previous command |
| pb_we | output | 1 | Page buffer write strobe |
| pb_addr | output | 16 | Page buffer word address |
| pb_wdata | output | 16 | Page buffer write word |
| rd_addr | output | 16 | Word address counter, used as the read address |
| rd_data | input | 16 | Flash word at `rd_addr` |

## Verification
The bench fills full 8-word pages at four base addresses, including one that reads across a 256-word boundary, and then reads every page back. A counter that increments before the first load byte would shift each page up by one word. A counter that skips the increment on the first read would read the first word twice.

Changing the instruction between the two bytes of a word must restart with a low byte and no increment. A design that kept the alternation would write a torn word.

Shifting in byte mode must keep bits 14:8, and unselected instruction codes must leave every output still. Either fault shows up in a later `cmd_out` value.

// File: rtl/jfp_pkg.sv
package jfp_pkg;

  localparam logic [3:0] IR_CMD  = 4'h5;
  localparam logic [3:0] IR_LOAD = 4'h6;
  localparam logic [3:0] IR_READ = 4'h7;

  localparam logic [6:0] OP_ADDR_LO = 7'h03;
  localparam logic [6:0] OP_ADDR_HI = 7'h07;

  typedef enum logic [1:0] {
    M_NONE = 2'd0,
    M_CMD  = 2'd1,
    M_LOAD = 2'd2,
    M_READ = 2'd3
  } dr_mode_e;

  function automatic dr_mode_e decode_ir(input logic [3:0] ir);
    case (ir)
      IR_CMD:  return M_CMD;
      IR_LOAD: return M_LOAD;
      IR_READ: return M_READ;
      default: return M_NONE;
    endcase
  endfunction

endpackage

// File: rtl/jfp_dr_shifter.sv
module jfp_dr_shifter
  import jfp_pkg::*;
#(
  parameter int CMD_W  = 15,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dr_mode_e          mode,
  input  logic              cap_en,
  input  logic              sh_en,
  input  logic              tdi,
  input  logic [CMD_W-1:0]  cap_full,
  input  logic [BYTE_W-1:0] cap_byte,
  output logic [CMD_W-1:0]  dr,
  output logic              tdo
);

  localparam int UP_W = CMD_W - BYTE_W;

  logic byte_mode;
  assign byte_mode = (mode == M_LOAD) || (mode == M_READ);

  // Low byte: shared by all three modes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr[BYTE_W-1:0] <= '0;
    end else if (cap_en && mode == M_CMD) begin
      dr[BYTE_W-1:0] <= cap_full[BYTE_W-1:0];
    end else if (cap_en && mode == M_READ) begin
      dr[BYTE_W-1:0] <= cap_byte;
    end else if (sh_en && mode == M_CMD) begin
      dr[BYTE_W-1:0] <= dr[BYTE_W:1];
    end else if (sh_en && byte_mode) begin
      dr[BYTE_W-1:0] <= {tdi, dr[BYTE_W-1:1]};
    end
  end

  // Upper part: only reachable in command mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr[CMD_W-1:BYTE_W] <= '0;
    end else if (cap_en && mode == M_CMD) begin
      dr[CMD_W-1:BYTE_W] <= cap_full[CMD_W-1:BYTE_W];
    end else if (sh_en && mode == M_CMD) begin
      dr[CMD_W-1:BYTE_W] <= {tdi, dr[CMD_W-1:BYTE_W+1]};
    end
  end

  assign tdo = (mode != M_NONE) ? dr[0] : 1'b0;

  assert_upper_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_mode && sh_en) |=> $stable(dr[CMD_W-1:BYTE_W]));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NONE) |-> !tdo);

  logic [UP_W-1:0] unused_w;
  assign unused_w = '0;

endmodule

// File: rtl/jfp_addr_seq.sv
module jfp_addr_seq #(
  parameter int ADDR_W = 16,
  parameter int CMD_W  = 15,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_chg,
  input  logic              ld_evt,
  input  logic              rd_evt,
  input  logic              cmd_upd,
  input  logic [CMD_W-1:0]  dr,
  output logic [ADDR_W-1:0] pc,
  output logic              hi_phase
);

  localparam int OP_W = CMD_W - BYTE_W;
  localparam int HI_W = ADDR_W - BYTE_W;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  logic first_pend;
  logic pre_inc;
  logic post_inc;
  logic lo_ld;
  logic hi_ld;

  assign pre_inc  = ld_evt && !hi_phase && !first_pend;
  assign post_inc = rd_evt && hi_phase;
  assign lo_ld    = cmd_upd && (dr[CMD_W-1:BYTE_W] == OP_W'(jfp_pkg::OP_ADDR_LO));
  assign hi_ld    = cmd_upd && (dr[CMD_W-1:BYTE_W] == OP_W'(jfp_pkg::OP_ADDR_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
    end else if (pre_inc || post_inc) begin
      pc <= step_addr(pc);
    end else begin
      if (lo_ld) pc[BYTE_W-1:0] <= dr[BYTE_W-1:0];
      if (hi_ld) pc[ADDR_W-1:BYTE_W] <= dr[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_phase   <= 1'b0;
      first_pend <= 1'b1;
    end else if (ir_chg) begin
      hi_phase   <= 1'b0;
      first_pend <= 1'b1;
    end else if (ld_evt || rd_evt) begin
      hi_phase <= !hi_phase;
      if (ld_evt) first_pend <= 1'b0;
    end
  end

  assert_hold_on_high_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_evt && hi_phase) |=> $stable(pc));

  assert_first_byte_no_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_evt && first_pend) |=> $stable(pc));

  assert_post_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && hi_phase) |=> (pc == $past(pc) + ADDR_W'(1)));

  assert_low_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !hi_phase) |=> $stable(pc));

  assert_restart_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ir_chg |=> ($stable(pc) && !hi_phase));

endmodule

// File: rtl/jfp_word_pack.sv
module jfp_word_pack #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_evt,
  input  logic                hi_phase,
  input  logic [BYTE_W-1:0]   byte_in,
  input  logic [ADDR_W-1:0]   pc,
  output logic                pb_we,
  output logic [ADDR_W-1:0]   pb_addr,
  output logic [2*BYTE_W-1:0] pb_wdata
);

  logic [BYTE_W-1:0] tmp_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmp_lo   <= '0;
      pb_we    <= 1'b0;
      pb_addr  <= '0;
      pb_wdata <= '0;
    end else begin
      pb_we <= ld_evt && hi_phase;
      if (ld_evt && !hi_phase) tmp_lo <= byte_in;
      if (ld_evt && hi_phase) begin
        pb_wdata <= {byte_in, tmp_lo};
        pb_addr  <= pc;
      end
    end
  end

  assert_we_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pb_we |=> !pb_we);

endmodule

// File: rtl/jtag_page_dr.sv
module jtag_page_dr
  import jfp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CMD_W  = 15,
  parameter int BYTE_W = 8
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic [3:0]          ir_code,
  input  logic                cap_dr,
  input  logic                shift_dr,
  input  logic                upd_dr,
  input  logic                rti,
  input  logic                tdi,
  output logic                tdo,
  output logic [CMD_W-1:0]    cmd_out,
  output logic                cmd_load,
  output logic                cmd_exec,
  input  logic [CMD_W-1:0]    cmd_result,
  output logic                pb_we,
  output logic [ADDR_W-1:0]   pb_addr,
  output logic [2*BYTE_W-1:0] pb_wdata,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic [2*BYTE_W-1:0] rd_data
);

  localparam int WORD_W = 2 * BYTE_W;

  logic [3:0]        ir_q;
  logic              ir_chg;
  dr_mode_e          mode;
  logic              cap_en;
  logic              sh_en;
  logic              cmd_upd;
  logic              ld_evt;
  logic              rd_evt;
  logic              hi_phase;
  logic              armed;
  logic [CMD_W-1:0]  dr;
  logic [BYTE_W-1:0] cap_byte;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) ir_q <= 4'h0;
    else         ir_q <= ir_code;
  end

  assign ir_chg  = (ir_code != ir_q);
  assign mode    = decode_ir(ir_code);
  assign cap_en  = cap_dr && !ir_chg;
  assign sh_en   = shift_dr && !ir_chg;
  assign cmd_upd = upd_dr && !ir_chg && (mode == M_CMD);
  assign ld_evt  = upd_dr && !ir_chg && (mode == M_LOAD);
  assign rd_evt  = cap_dr && !ir_chg && (mode == M_READ);

  assign cap_byte = hi_phase ? rd_data[WORD_W-1:BYTE_W] : rd_data[BYTE_W-1:0];

  jfp_dr_shifter #(.CMD_W(CMD_W), .BYTE_W(BYTE_W)) u_shift (
    .clk      (tck),
    .rst_n    (trst_n),
    .mode     (mode),
    .cap_en   (cap_en),
    .sh_en    (sh_en),
    .tdi      (tdi),
    .cap_full (cmd_result),
    .cap_byte (cap_byte),
    .dr       (dr),
    .tdo      (tdo)
  );

  jfp_addr_seq #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .BYTE_W(BYTE_W)) u_seq (
    .clk      (tck),
    .rst_n    (trst_n),
    .ir_chg   (ir_chg),
    .ld_evt   (ld_evt),
    .rd_evt   (rd_evt),
    .cmd_upd  (cmd_upd),
    .dr       (dr),
    .pc       (rd_addr),
    .hi_phase (hi_phase)
  );

  jfp_word_pack #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_pack (
    .clk      (tck),
    .rst_n    (trst_n),
    .ld_evt   (ld_evt),
    .hi_phase (hi_phase),
    .byte_in  (dr[BYTE_W-1:0]),
    .pc       (rd_addr),
    .pb_we    (pb_we),
    .pb_addr  (pb_addr),
    .pb_wdata (pb_wdata)
  );

  // Command application and execute pulse.
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      cmd_out  <= '0;
      cmd_load <= 1'b0;
      cmd_exec <= 1'b0;
      armed    <= 1'b0;
    end else begin
      cmd_load <= cmd_upd;
      cmd_exec <= rti && armed && !ir_chg && (mode == M_CMD);
      if (cmd_upd) cmd_out <= dr;
      if (ir_chg)                           armed <= 1'b0;
      else if (cmd_upd)                     armed <= 1'b1;
      else if (rti && (mode == M_CMD))      armed <= 1'b0;
    end
  end

  assert_exec_after_idle_R3: assert property (@(posedge tck) disable iff (!trst_n)
    cmd_exec |-> $past(rti));

  assert_load_after_update_R3: assert property (@(posedge tck) disable iff (!trst_n)
    cmd_load |-> $past(upd_dr));

  assert_we_after_update_R6: assert property (@(posedge tck) disable iff (!trst_n)
    pb_we |-> $past(upd_dr));

  assert_we_at_counter_R7: assert property (@(posedge tck) disable iff (!trst_n)
    pb_we |-> (pb_addr == rd_addr));

endmodule

// File: tb/tb_jtag_page_dr.sv
module tb_jtag_page_dr;

  localparam int PAGE = 8;

  logic        clk = 1'b0;
  logic        trst_n = 1'b0;
  logic [3:0]  ir_code = 4'h0;
  logic        cap_dr = 1'b0, shift_dr = 1'b0, upd_dr = 1'b0, rti = 1'b0, tdi = 1'b0;
  logic        tdo;
  logic [14:0] cmd_out;
  logic        cmd_load, cmd_exec;
  logic [14:0] cmd_result = '0;
  logic        pb_we;
  logic [15:0] pb_addr, pb_wdata, rd_addr, rd_data;

  logic [15:0] mem [0:255];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  jtag_page_dr dut (
    .tck(clk), .trst_n(trst_n), .ir_code(ir_code), .cap_dr(cap_dr),
    .shift_dr(shift_dr), .upd_dr(upd_dr), .rti(rti), .tdi(tdi), .tdo(tdo),
    .cmd_out(cmd_out), .cmd_load(cmd_load), .cmd_exec(cmd_exec),
    .cmd_result(cmd_result), .pb_we(pb_we), .pb_addr(pb_addr),
    .pb_wdata(pb_wdata), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign rd_data = mem[rd_addr[7:0]];

  always @(posedge clk) if (pb_we) mem[pb_addr[7:0]] <= pb_wdata;

  function automatic logic [15:0] pat(input int base, input int w);
    return 16'((base * 16'h0131) ^ (w * 16'h2357) ^ 16'hC3A5);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_ir(input logic [3:0] code);
    @(negedge clk); ir_code = code;
    @(negedge clk);
  endtask

  task automatic pulse_cap();
    @(negedge clk); cap_dr = 1'b1;
    @(negedge clk); cap_dr = 1'b0;
  endtask

  task automatic pulse_upd();
    @(negedge clk); upd_dr = 1'b1;
    @(negedge clk); upd_dr = 1'b0;
  endtask

  task automatic pulse_rti();
    @(negedge clk); rti = 1'b1;
    @(negedge clk); rti = 1'b0;
  endtask

  task automatic shift_n(input int n, input logic [14:0] din, output logic [14:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dout[i] = tdo;
      shift_dr = 1'b1;
      tdi = din[i];
    end
    @(negedge clk); shift_dr = 1'b0; tdi = 1'b0;
  endtask

  task automatic load_addr(input logic [15:0] a);
    logic [14:0] junk;
    shift_n(15, {7'h03, a[7:0]}, junk);
    pulse_upd();
    shift_n(15, {7'h07, a[15:8]}, junk);
    pulse_upd();
    chk(rd_addr == a, "R4", "address after load commands", 32'(rd_addr), 32'(a));
  endtask

  task automatic load_page(input logic [15:0] base);
    logic [14:0] junk;
    logic [15:0] d;
    set_ir(4'h5);
    load_addr(base);
    set_ir(4'h6);
    for (int w = 0; w < PAGE; w++) begin
      d = pat(int'(base), w);
      shift_n(8, {7'h00, d[7:0]}, junk);
      pulse_upd();
      chk(rd_addr == base + 16'(w), "R7", "counter after low byte", 32'(rd_addr), 32'(base + 16'(w)));
      chk(pb_we == 1'b0, "R6", "no write on low byte", 32'(pb_we), 32'd0);
      shift_n(8, {7'h00, d[15:8]}, junk);
      pulse_upd();
      chk(pb_we == 1'b1, "R6", "write strobe on high byte", 32'(pb_we), 32'd1);
      chk(pb_addr == base + 16'(w), "R6", "write address", 32'(pb_addr), 32'(base + 16'(w)));
      chk(pb_wdata == d, "R6", "write word", 32'(pb_wdata), 32'(d));
      @(negedge clk);
      chk(pb_we == 1'b0, "R6", "strobe lasts one cycle", 32'(pb_we), 32'd0);
    end
    chk(rd_addr == base + 16'(PAGE - 1), "R7", "counter stays on last word",
        32'(rd_addr), 32'(base + 16'(PAGE - 1)));
  endtask

  task automatic read_page(input logic [15:0] base);
    logic [14:0] got;
    logic [15:0] d;
    set_ir(4'h5);
    load_addr(base);
    set_ir(4'h7);
    for (int w = 0; w < PAGE; w++) begin
      d = pat(int'(base), w);
      pulse_cap();
      chk(rd_addr == base + 16'(w), "R8", "counter held on low capture", 32'(rd_addr), 32'(base + 16'(w)));
      shift_n(8, 15'h0, got);
      chk(got[7:0] == d[7:0], "R8", "low byte read", 32'(got[7:0]), 32'(d[7:0]));
      pulse_cap();
      chk(rd_addr == base + 16'(w + 1), "R9", "counter after high capture",
          32'(rd_addr), 32'(base + 16'(w + 1)));
      shift_n(8, 15'h0, got);
      chk(got[7:0] == d[15:8], "R8", "high byte read", 32'(got[7:0]), 32'(d[15:8]));
    end
    chk(rd_addr == base + 16'(PAGE), "R9", "counter in next page", 32'(rd_addr), 32'(base + 16'(PAGE)));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [14:0] got;
    logic [15:0] keep;
    logic [15:0] bases [4];
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    bases[0] = 16'h0000; bases[1] = 16'h1218; bases[2] = 16'h0040; bases[3] = 16'h00F8;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(tdo == 1'b0, "R1", "tdo", 32'(tdo), 0);
    chk(pb_we == 1'b0 && cmd_load == 1'b0 && cmd_exec == 1'b0, "R1", "strobes",
        32'({pb_we, cmd_load, cmd_exec}), 0);
    chk(rd_addr == 16'h0, "R1", "address", 32'(rd_addr), 0);
    trst_n = 1'b1;

    // R2, R3: command capture/shift/update/execute
    set_ir(4'h5);
    cmd_result = 15'h5A3C;
    pulse_cap();
    shift_n(15, 15'h1234, got);
    chk(got == 15'h5A3C, "R2", "result shifted out", 32'(got), 32'h5A3C);
    pulse_upd();
    chk(cmd_out == 15'h1234, "R2", "command shifted in", 32'(cmd_out), 32'h1234);
    chk(cmd_load == 1'b1, "R3", "load pulse", 32'(cmd_load), 1);
    @(negedge clk);
    chk(cmd_load == 1'b0, "R3", "load pulse ends", 32'(cmd_load), 0);
    pulse_rti();
    chk(cmd_exec == 1'b1, "R3", "execute pulse", 32'(cmd_exec), 1);
    @(negedge clk);
    chk(cmd_exec == 1'b0, "R3", "execute ends", 32'(cmd_exec), 0);
    pulse_rti();
    chk(cmd_exec == 1'b0, "R3", "no second execute", 32'(cmd_exec), 0);

    // R5: byte mode shifts only bits 7:0
    shift_n(15, {7'h55, 8'h00}, got);
    set_ir(4'h6);
    shift_n(8, 15'h005A, got);
    chk(got[7:0] == 8'h00, "R5", "byte shifted out", 32'(got[7:0]), 0);
    set_ir(4'h5);
    pulse_upd();
    chk(cmd_out == {7'h55, 8'h5A}, "R5", "upper bits kept", 32'(cmd_out), 32'({7'h55, 8'h5A}));
    keep = {1'b0, cmd_out};

    // R11: unselected instruction ignores everything
    set_ir(4'hC);
    chk(tdo == 1'b0, "R11", "tdo low", 32'(tdo), 0);
    pulse_cap();
    shift_n(4, 15'h7FFF, got);
    chk(got == 15'h0, "R11", "no serial output", 32'(got), 0);
    pulse_upd();
    chk(pb_we == 1'b0 && cmd_load == 1'b0, "R11", "no update effect", 32'({pb_we, cmd_load}), 0);
    pulse_rti();
    chk(cmd_exec == 1'b0, "R11", "no execute", 32'(cmd_exec), 0);
    chk(rd_addr == 16'h0, "R11", "address unchanged", 32'(rd_addr), 0);
    set_ir(4'h5);
    pulse_upd();
    chk({1'b0, cmd_out} == keep, "R11", "register unchanged", 32'(cmd_out), 32'(keep));

    // R6..R9: sweep of full pages
    for (int b = 0; b < 4; b++) load_page(bases[b]);
    for (int b = 0; b < 4; b++) read_page(bases[b]);

    // R10: instruction change between the bytes of a word
    set_ir(4'h5);
    load_addr(16'h0030);
    set_ir(4'h6);
    shift_n(8, 15'h0011, got);
    pulse_upd();
    set_ir(4'h7);
    set_ir(4'h6);
    chk(rd_addr == 16'h0030, "R10", "address kept across change", 32'(rd_addr), 32'h30);
    shift_n(8, 15'h0022, got);
    pulse_upd();
    chk(pb_we == 1'b0 && rd_addr == 16'h0030, "R10", "restart on low byte, no step",
        32'({pb_we, rd_addr}), 32'h30);
    shift_n(8, 15'h0033, got);
    pulse_upd();
    chk(pb_we == 1'b1 && pb_wdata == 16'h3322 && pb_addr == 16'h0030, "R10", "whole word written",
        32'({pb_addr, pb_wdata}), 32'h0030_3322);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule